// File: doc/BRIEF.md
# Long Multiply-Accumulate Unit

This unit multiplies two data words and can add an accumulator to the product. One iterative shift-add datapath covers all six operations: the short forms produce a single-width result, and the long forms produce a double-width result, signed or unsigned, with or without a double-width accumulator. A caller raises `start_i` for one cycle with the operands and a 3-bit operation code. It then waits for the one-cycle `done_o` pulse. While `busy_o` is high the unit takes no new work.

The accumulator is taken as two words: the high word `acc_hi_i` and the low word `acc_lo_i`. Long results come back split the same way, on `res_hi_o` and `res_lo_o`. Short results use `res_hi_o` only. Alongside each result the unit reports a zero flag and a negative flag. Operation codes 2 and 3 are reserved. A reserved code is reported as illegal and leaves the results unchanged.

Top module: `lmac_unit`

## Requirements
- R1: After reset `busy_o`, `done_o`, `illegal_o`, `flag_n_o`, `flag_z_o`, `res_hi_o` and `res_lo_o` are all zero.
- R2: Operation code 0 places the low DATA_W bits of `src_a_i*src_b_i` on `res_hi_o` and drives `res_lo_o` to zero.
- R3: Operation code 1 places the low DATA_W bits of `src_a_i*src_b_i + acc_lo_i` on `res_hi_o` and drives `res_lo_o` to zero.
- R4: Operation code 4 forms the unsigned 2*DATA_W-bit product. Its upper half goes on `res_hi_o` and its lower half on `res_lo_o`.
- R5: Operation code 6 forms the same split product with both sources sign-extended.
- R6: Operation code 7 forms the unsigned product plus `{acc_hi_i, acc_lo_i}`, taken modulo 2^(2*DATA_W), and returns it split as in R4.
- R7: Operation code 5 forms the signed product plus `{acc_hi_i, acc_lo_i}`, taken modulo 2^(2*DATA_W), and returns it split as in R4.
- R8: For operation code 2 or 3, `done_o` and `illegal_o` both go high for one cycle, on the first clock edge after the accepted start. The results and flags keep their previous values, and `busy_o` stays low.
- R9: After a start with a legal code is accepted, `busy_o` stays high until the unit finishes. `done_o` is then high for exactly one cycle, DATA_W+1 clock edges after the accepting edge counting that edge, and `illegal_o` stays low.
- R10: A `start_i` pulse while `busy_o` is high is ignored: the result of the running operation is unaffected and no extra `done_o` follows.
- R11: `flag_z_o` is high exactly when the result is zero. For long forms the result is the 2*DATA_W-bit value; for short forms it is the DATA_W-bit value.
- R12: `flag_n_o` equals the most significant bit of the result, with the result width chosen as in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when not busy |
| op_i | input | 3 | Operation code |
| src_a_i | input | DATA_W | Multiplicand |
| src_b_i | input | DATA_W | Multiplier |
| acc_hi_i | input | DATA_W | Accumulator high word |
| acc_lo_i | input | DATA_W | Accumulator low word (also the short-form addend) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Reserved operation code seen, pulses with done_o |
| res_hi_o | output | DATA_W | High result word, or the short-form result |
| res_lo_o | output | DATA_W | Low result word |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |

## Verification
The bench builds the unit with DATA_W set to 4. At that width every operand pair can be tried for all six legal codes, and the accumulator words are derived from each operand pair. The sweep therefore covers the most negative operand in the signed forms, products of all ones, and accumulations that wrap past 2^8. It also reaches both flags in every form, the completion latency of every run, the reserved codes, and starts issued while the unit is busy.

// File: rtl/lmac_pkg.sv
package lmac_pkg;
  typedef enum logic [2:0] {
    OP_MUL   = 3'd0,
    OP_MLA   = 3'd1,
    OP_RSV2  = 3'd2,
    OP_RSV3  = 3'd3,
    OP_UMULL = 3'd4,
    OP_SMLAL = 3'd5,
    OP_SMULL = 3'd6,
    OP_UMLAL = 3'd7
  } lmac_op_e;

  typedef struct packed {
    logic is_signed;
    logic accum;
    logic is_long;
    logic illegal;
  } lmac_ctl_t;
endpackage

// File: rtl/lmac_decode.sv
module lmac_decode
  import lmac_pkg::*;
(
  input  logic [2:0] op_i,
  output lmac_ctl_t  ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (lmac_op_e'(op_i))
      OP_MUL:   ctl_o = '{is_signed: 1'b0, accum: 1'b0, is_long: 1'b0, illegal: 1'b0};
      OP_MLA:   ctl_o = '{is_signed: 1'b0, accum: 1'b1, is_long: 1'b0, illegal: 1'b0};
      OP_UMULL: ctl_o = '{is_signed: 1'b0, accum: 1'b0, is_long: 1'b1, illegal: 1'b0};
      OP_SMLAL: ctl_o = '{is_signed: 1'b1, accum: 1'b1, is_long: 1'b1, illegal: 1'b0};
      OP_SMULL: ctl_o = '{is_signed: 1'b1, accum: 1'b0, is_long: 1'b1, illegal: 1'b0};
      OP_UMLAL: ctl_o = '{is_signed: 1'b0, accum: 1'b1, is_long: 1'b1, illegal: 1'b0};
      default:  ctl_o = '{is_signed: 1'b0, accum: 1'b0, is_long: 1'b0, illegal: 1'b1};
    endcase
  end
endmodule

// File: rtl/lmac_engine.sv
module lmac_engine #(
  parameter int DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  signed_i,
  input  logic [DATA_W-1:0]     a_i,
  input  logic [DATA_W-1:0]     b_i,
  input  logic [2*DATA_W-1:0]   addend_i,
  output logic                  busy_o,
  output logic                  last_o,
  output logic [2*DATA_W-1:0]   sum_nx_o
);
  localparam int WIDE_W = 2 * DATA_W;
  localparam int CNT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [WIDE_W-1:0] acc_q, mcand_q;
  logic [DATA_W-1:0] mplier_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sgn_q, busy_q;

  assign last_o = busy_q && (cnt_q == CNT_W'(DATA_W - 1));

  // top multiplier bit carries negative weight in signed mode
  always_comb begin
    sum_nx_o = acc_q;
    if (mplier_q[0])
      sum_nx_o = (sgn_q && last_o) ? acc_q - mcand_q : acc_q + mcand_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      sgn_q    <= 1'b0;
      busy_q   <= 1'b0;
    end else if (load_i) begin
      acc_q    <= addend_i;
      mcand_q  <= signed_i ? {{DATA_W{a_i[DATA_W-1]}}, a_i} : {{DATA_W{1'b0}}, a_i};
      mplier_q <= b_i;
      cnt_q    <= '0;
      sgn_q    <= signed_i;
      busy_q   <= 1'b1;
    end else if (busy_q) begin
      acc_q    <= sum_nx_o;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
      cnt_q    <= cnt_q + 1'b1;
      busy_q   <= !last_o;
    end
  end

  assign busy_o = busy_q;

  p_no_load_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !load_i);
  p_count_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !last_o |=> busy_q && cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/lmac_flags.sv
module lmac_flags #(
  parameter int DATA_W = 32
) (
  input  logic [2*DATA_W-1:0] val_i,
  input  logic                is_long_i,
  output logic                n_o,
  output logic                z_o
);
  always_comb begin
    if (is_long_i) begin
      n_o = val_i[2*DATA_W-1];
      z_o = (val_i == '0);
    end else begin
      n_o = val_i[DATA_W-1];
      z_o = (val_i[DATA_W-1:0] == '0);
    end
  end
endmodule

// File: rtl/lmac_unit.sv
module lmac_unit
  import lmac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [DATA_W-1:0] acc_hi_i,
  input  logic [DATA_W-1:0] acc_lo_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic [DATA_W-1:0] res_hi_o,
  output logic [DATA_W-1:0] res_lo_o,
  output logic              flag_n_o,
  output logic              flag_z_o
);
  localparam int WIDE_W = 2 * DATA_W;

  lmac_ctl_t         ctl;
  logic              accept, load, last, n_nx, z_nx, long_q;
  logic [WIDE_W-1:0] addend, sum_nx;

  lmac_decode u_dec (.op_i(op_i), .ctl_o(ctl));

  assign accept = start_i && !busy_o;
  assign load   = accept && !ctl.illegal;
  assign addend = !ctl.accum ? '0 :
                  ctl.is_long ? {acc_hi_i, acc_lo_i} : {{DATA_W{1'b0}}, acc_lo_i};

  lmac_engine #(.DATA_W(DATA_W)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .signed_i (ctl.is_signed),
    .a_i      (src_a_i),
    .b_i      (src_b_i),
    .addend_i (addend),
    .busy_o   (busy_o),
    .last_o   (last),
    .sum_nx_o (sum_nx)
  );

  lmac_flags #(.DATA_W(DATA_W)) u_flg (
    .val_i     (sum_nx),
    .is_long_i (long_q),
    .n_o       (n_nx),
    .z_o       (z_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      long_q    <= 1'b0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      res_hi_o  <= '0;
      res_lo_o  <= '0;
      flag_n_o  <= 1'b0;
      flag_z_o  <= 1'b0;
    end else begin
      done_o    <= last || (accept && ctl.illegal);
      illegal_o <= accept && ctl.illegal;
      if (load) long_q <= ctl.is_long;
      if (last) begin
        res_hi_o <= long_q ? sum_nx[WIDE_W-1:DATA_W] : sum_nx[DATA_W-1:0];
        res_lo_o <= long_q ? sum_nx[DATA_W-1:0] : '0;
        flag_n_o <= n_nx;
        flag_z_o <= z_nx;
      end
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_ends_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !illegal_o |-> $fell(busy_o));
  p_illegal_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> done_o && !busy_o);
  p_illegal_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $stable(res_hi_o) && $stable(res_lo_o) && $stable(flag_z_o) && $stable(flag_n_o));
  p_short_lo_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !illegal_o && !long_q |-> res_lo_o == '0);
  p_zero_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !illegal_o |-> flag_z_o == (long_q ? ({res_hi_o, res_lo_o} == '0) : (res_hi_o == '0)));
  p_neg_flag_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !illegal_o && long_q |-> flag_n_o == res_hi_o[DATA_W-1]);
endmodule

// File: tb/lmac_unit_test.sv
module lmac_unit_test;
  localparam int DW     = 4;
  localparam int CLK_PS = 10;

  logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0]    op = '0;
  logic [DW-1:0] a = '0, b = '0, ahi = '0, alo = '0;
  logic          busy, done, illegal, fn, fz;
  logic [DW-1:0] rhi, rlo;
  int checks = 0, errors = 0;

  always #(CLK_PS/2) clk = ~clk;

  lmac_unit #(.DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .src_a_i(a), .src_b_i(b), .acc_hi_i(ahi), .acc_lo_i(alo),
    .busy_o(busy), .done_o(done), .illegal_o(illegal),
    .res_hi_o(rhi), .res_lo_o(rlo), .flag_n_o(fn), .flag_z_o(fz)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h op=%0d a=%0h b=%0h", req, act, exp, op, a, b);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic [DW-1:0] xa, xb, xh, xl, input bit intrude);
    logic [2*DW-1:0] ea, eb, ad, full;
    logic [DW-1:0]   ehi, elo;
    bit lng, sgn, acc;
    int n;
    lng = o[2]; sgn = (o == 3'd5) || (o == 3'd6); acc = (o == 3'd1) || (o == 3'd5) || (o == 3'd7);
    ea = sgn ? {{DW{xa[DW-1]}}, xa} : {{DW{1'b0}}, xa};
    eb = sgn ? {{DW{xb[DW-1]}}, xb} : {{DW{1'b0}}, xb};
    ad = !acc ? '0 : lng ? {xh, xl} : {{DW{1'b0}}, xl};
    full = ea * eb + ad;
    ehi = lng ? full[2*DW-1:DW] : full[DW-1:0];
    elo = lng ? full[DW-1:0] : '0;
    @(negedge clk);
    op = o; a = xa; b = xb; ahi = xh; alo = xl; start = 1'b1;
    @(negedge clk);
    start = 1'b0; n = 1;
    if (intrude) begin
      op = 3'd4; a = '1; b = '1; ahi = '1; alo = '1; start = 1'b1;  // R10 ignored start
    end
    while (!done && n < 40) begin
      @(negedge clk); n++; start = 1'b0;
    end
    chk(n == DW + 1, "R9 latency", n, DW + 1);
    chk(!illegal, "R9 no illegal", illegal, 0);
    case (o)
      3'd0: chk(rhi == ehi && rlo == elo, "R2 mul", {rhi, rlo}, {ehi, elo});
      3'd1: chk(rhi == ehi && rlo == elo, "R3 mla", {rhi, rlo}, {ehi, elo});
      3'd4: chk(rhi == ehi && rlo == elo, "R4 umull", {rhi, rlo}, {ehi, elo});
      3'd6: chk(rhi == ehi && rlo == elo, "R5 smull", {rhi, rlo}, {ehi, elo});
      3'd7: chk(rhi == ehi && rlo == elo, "R6 umlal", {rhi, rlo}, {ehi, elo});
      default: chk(rhi == ehi && rlo == elo, "R7 smlal", {rhi, rlo}, {ehi, elo});
    endcase
    chk(fz == (lng ? (full == '0) : (full[DW-1:0] == '0)), "R11 zero flag", fz, !fz);
    chk(fn == (lng ? full[2*DW-1] : full[DW-1]), "R12 neg flag", fn, !fn);
    @(negedge clk);
    chk(!done, "R9 single pulse", done, 0);
    if (intrude) chk(!busy, "R10 no extra run", busy, 0);
  endtask

  initial begin
    #(CLK_PS * 200000);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] sh, sl;
    bit            sz, sn;
    #(CLK_PS * 3 + 1);
    chk(!busy && !done && !illegal && !fn && !fz && rhi == 0 && rlo == 0, "R1 reset",
        {busy, done, illegal, fn, fz, rhi, rlo}, 0);
    rst_n = 1'b1;
    foreach (op_list[i]) begin end
    for (int oi = 0; oi < 8; oi++) begin
      if (oi == 2 || oi == 3) continue;
      for (int xa = 0; xa < (1 << DW); xa++)
        for (int xb = 0; xb < (1 << DW); xb++)
          run(3'(oi), DW'(xa), DW'(xb), DW'(xa * 3 + xb), DW'(xb * 5 + xa + oi), (xa == xb));
    end
    // R8 reserved codes leave state alone
    for (int r = 2; r < 4; r++) begin
      run(3'd6, 4'h8, 4'h3, 4'h0, 4'h0, 1'b0);
      sh = rhi; sl = rlo; sz = fz; sn = fn;
      @(negedge clk);
      op = 3'(r); a = 4'h5; b = 4'h7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done && illegal, "R8 illegal pulse", {done, illegal}, 2'b11);
      chk(!busy, "R8 not busy", busy, 0);
      chk(rhi == sh && rlo == sl && fz == sz && fn == sn, "R8 hold", {rhi, rlo}, {sh, sl});
      @(negedge clk);
      chk(!done && !illegal, "R8 one cycle", {done, illegal}, 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int op_list[1];
endmodule